// File: doc/BRIEF.md
# Access Replay Consistency Checker

This block sits beside a home memory node and checks, end to end, that the memory system behaved sequentially consistently. It does not protect any single component. Each processor load or store sends the checker a report with four fields: address, access kind, data word and a logical timestamp. The timestamps respect causality: an access that causes another carries the smaller stamp. The checker replays the reports against a private shadow copy of memory. A replayed store writes the shadow word. A replayed load must see exactly the value of the latest store before it in logical time.

Reports wait in a 16-slot priority buffer that also acts as a reordering window. One report is released, always the one with the smallest timestamp, only when all slots are occupied. Equal stamps leave in arrival order. A mismatching load raises a one-cycle recovery request. The first failing address, together with the expected and observed data, stays latched until a synchronous flush restarts the checker. The flush empties the buffer, zeroes the shadow copy and clears the latched error.

Top module: `replay_checker`

## Requirements
- R1: A report is accepted on a rising clock edge where `rptValid` and `rptReady` are both high. Each accepted report fills exactly one buffer slot.
- R2: The buffer holds 16 reports. `rptReady` is low while all 16 slots are occupied and high otherwise (flush aside). A report is released only while the buffer is full, so a load among 15 or fewer buffered reports is never checked.
- R3: Released reports are replayed in ascending timestamp order, whatever their arrival order.
- R4: Among reports with equal timestamps, the one that arrived first is replayed first.
- R5: A replayed store writes its data to the shadow word selected by the low 6 address bits. Addresses that differ only above bit 5 share one word.
- R6: All 64 shadow words are zero after reset. A load from a word never stored passes only if its data is zero.
- R7: A replayed load whose data differs from the shadow word drives `errPulse` high for exactly one cycle. Counting the edge that accepts the report which fills the buffer, the pulse appears two edges later.
- R8: The first mismatch latches `errValid`, `errAddr`, `errExpected` (the shadow value) and `errObserved` (the load data). Later mismatches still pulse but leave the latched values unchanged until a flush.
- R9: While `flush` is high, `rptReady` is low. A flush discards every buffered report, zeroes the shadow copy and clears the latched error.
- R10: After reset, `rptReady` is high and `errPulse` and `errValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous restart: empties buffer, shadow and error latch |
| rptValid | input | 1 | Report present |
| rptReady | output | 1 | Checker can take a report |
| rptAddr | input | 10 | Word address of the access |
| rptIsStore | input | 1 | 1 = store, 0 = load |
| rptData | input | 32 | Data stored or data the load returned |
| rptTime | input | 16 | Logical timestamp |
| errPulse | output | 1 | One-cycle recovery request on a mismatch |
| errValid | output | 1 | An error is latched |
| errAddr | output | 10 | Address of the first failing load |
| errExpected | output | 32 | Shadow value for that load |
| errObserved | output | 32 | Value that load returned |

## Verification
Several cases are built so that a wrong design would report a mismatch where there is none, or miss a real one:
- Reports arrive with their timestamps reversed. A checker that replayed in arrival order would flag a correct load, or accept a stale one.
- Two stores carry the same stamp. Favouring the later arrival would leave the wrong value in shadow memory and raise a false mismatch.
- Two consecutive mismatches are sent. Overwriting the latch on the second one would change the reported address.
- The bench confirms that nothing is released while 15 reports are buffered. It counts the exact edge on which the pulse appears and falls.
- A flush is applied over a pending bad load. A flush that left that load in the buffer would let it raise an error later.
- Aliased addresses and never-written words are used. Wrong shadow indexing would break the aliased pass, and non-zero reset contents would turn the zero-data load into a false mismatch.

// File: rtl/replay_pkg.sv
package replay_pkg;

  // Strobes from the control unit to the datapath, one cycle each.
  typedef struct packed {
    logic push;        // write incoming report into the next free slot
    logic pop;         // release the oldest-stamped slot into the replay stage
    logic applyStore;  // replay stage holds a store: update shadow word
    logic checkLoad;   // replay stage holds a load: compare with shadow word
    logic clearAll;    // synchronous restart of storage and error latch
  } ctrlStrobes_t;

endpackage

// File: rtl/replay_ctrl.sv
module replay_ctrl
  import replay_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             rptValid,
  output logic             rptReady,
  input  logic             stageIsStore,
  output logic [CNT_W-1:0] fillLevel,
  output ctrlStrobes_t     strobes
);

  logic [CNT_W-1:0] count;
  logic             stageValid;
  logic             full;

  assign full      = (count == CNT_W'(DEPTH));
  assign rptReady  = !full && !flush;
  assign fillLevel = count;

  always_comb begin
    strobes            = '0;
    strobes.clearAll   = flush;
    strobes.push       = rptValid && rptReady;
    strobes.pop        = full && !flush;
    strobes.applyStore = stageValid && stageIsStore && !flush;
    strobes.checkLoad  = stageValid && !stageIsStore && !flush;
  end

  // Occupancy: push and pop never coincide because push needs a free slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      stageValid <= 1'b0;
    end else if (flush) begin
      count      <= '0;
      stageValid <= 1'b0;
    end else begin
      stageValid <= strobes.pop;
      if (strobes.push)     count <= count + 1'b1;
      else if (strobes.pop) count <= count - 1'b1;
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_accept_fills_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rptValid && rptReady) |=> (count == $past(count) + 1'b1));

  p_full_releases_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && !flush) |=> (count == CNT_W'(DEPTH - 1) && stageValid));

  p_stage_needs_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stageValid |-> $past(count == CNT_W'(DEPTH)));

endmodule

// File: rtl/replay_datapath.sv
module replay_datapath
  import replay_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 32,
  parameter int TIME_W       = 16,
  parameter int DEPTH        = 16,
  parameter int SHADOW_WORDS = 64,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SEL_W = $clog2(DEPTH),
  localparam int IDX_W = $clog2(SHADOW_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [CNT_W-1:0]  fillLevel,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              inIsStore,
  input  logic [DATA_W-1:0] inData,
  input  logic [TIME_W-1:0] inTime,
  output logic              stageIsStore,
  output logic              errPulse,
  output logic              errValid,
  output logic [ADDR_W-1:0] errAddr,
  output logic [DATA_W-1:0] errExpected,
  output logic [DATA_W-1:0] errObserved
);

  // Slots stay in arrival order: slot 0 is the oldest arrival.
  logic [ADDR_W-1:0] slotAddr  [DEPTH];
  logic              slotStore [DEPTH];
  logic [DATA_W-1:0] slotData  [DEPTH];
  logic [TIME_W-1:0] slotTime  [DEPTH];

  logic [SEL_W-1:0]  selIdx;
  logic [TIME_W-1:0] selTime;

  // Smallest stamp wins; strict compare keeps the lower slot on ties (R4).
  always_comb begin
    selIdx  = '0;
    selTime = slotTime[0];
    for (int i = 1; i < DEPTH; i++) begin
      if (slotTime[i] < selTime) begin
        selTime = slotTime[i];
        selIdx  = SEL_W'(i);
      end
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slotAddr[i]  <= '0;
          slotStore[i] <= 1'b0;
          slotData[i]  <= '0;
          slotTime[i]  <= '0;
        end else if (strobes.pop && (SEL_W'(i) >= selIdx)) begin
          if (i < DEPTH - 1) begin
            slotAddr[i]  <= slotAddr[(i < DEPTH - 1) ? i + 1 : i];
            slotStore[i] <= slotStore[(i < DEPTH - 1) ? i + 1 : i];
            slotData[i]  <= slotData[(i < DEPTH - 1) ? i + 1 : i];
            slotTime[i]  <= slotTime[(i < DEPTH - 1) ? i + 1 : i];
          end
        end else if (strobes.push && (fillLevel == CNT_W'(i))) begin
          slotAddr[i]  <= inAddr;
          slotStore[i] <= inIsStore;
          slotData[i]  <= inData;
          slotTime[i]  <= inTime;
        end
      end
    end
  endgenerate

  // Replay stage: one released report per pop.
  logic [ADDR_W-1:0] stAddr;
  logic [DATA_W-1:0] stData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stAddr       <= '0;
      stData       <= '0;
      stageIsStore <= 1'b0;
    end else if (strobes.pop) begin
      stAddr       <= slotAddr[selIdx];
      stData       <= slotData[selIdx];
      stageIsStore <= slotStore[selIdx];
    end
  end

  // Shadow memory indexed by low address bits.
  logic [DATA_W-1:0] shadow [SHADOW_WORDS];
  logic [IDX_W-1:0]  stIdx;
  logic              mismatch;

  assign stIdx    = stAddr[IDX_W-1:0];
  assign mismatch = strobes.checkLoad && (shadow[stIdx] != stData);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < SHADOW_WORDS; w++) shadow[w] <= '0;
    end else if (strobes.clearAll) begin
      for (int w = 0; w < SHADOW_WORDS; w++) shadow[w] <= '0;
    end else if (strobes.applyStore) begin
      shadow[stIdx] <= stData;
    end
  end

  // Error pulse and first-error latch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errPulse    <= 1'b0;
      errValid    <= 1'b0;
      errAddr     <= '0;
      errExpected <= '0;
      errObserved <= '0;
    end else if (strobes.clearAll) begin
      errPulse    <= 1'b0;
      errValid    <= 1'b0;
      errAddr     <= '0;
      errExpected <= '0;
      errObserved <= '0;
    end else begin
      errPulse <= mismatch;
      if (mismatch && !errValid) begin
        errValid    <= 1'b1;
        errAddr     <= stAddr;
        errExpected <= shadow[stIdx];
        errObserved <= stData;
      end
    end
  end

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    errPulse |=> !errPulse);

  p_pulse_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    errPulse |-> errValid);

  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (errValid && !strobes.clearAll) |=>
      (errValid && $stable(errAddr) && $stable(errExpected) && $stable(errObserved)));

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clearAll |=> (!errValid && !errPulse));

endmodule

// File: rtl/replay_checker.sv
module replay_checker
  import replay_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 32,
  parameter int TIME_W       = 16,
  parameter int DEPTH        = 16,
  parameter int SHADOW_WORDS = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              rptValid,
  output logic              rptReady,
  input  logic [ADDR_W-1:0] rptAddr,
  input  logic              rptIsStore,
  input  logic [DATA_W-1:0] rptData,
  input  logic [TIME_W-1:0] rptTime,
  output logic              errPulse,
  output logic              errValid,
  output logic [ADDR_W-1:0] errAddr,
  output logic [DATA_W-1:0] errExpected,
  output logic [DATA_W-1:0] errObserved
);

  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] fillLevel;
  logic             stageIsStore;

  replay_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .rptValid     (rptValid),
    .rptReady     (rptReady),
    .stageIsStore (stageIsStore),
    .fillLevel    (fillLevel),
    .strobes      (strobes)
  );

  replay_datapath #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .TIME_W       (TIME_W),
    .DEPTH        (DEPTH),
    .SHADOW_WORDS (SHADOW_WORDS)
  ) i_datapath (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .fillLevel    (fillLevel),
    .inAddr       (rptAddr),
    .inIsStore    (rptIsStore),
    .inData       (rptData),
    .inTime       (rptTime),
    .stageIsStore (stageIsStore),
    .errPulse     (errPulse),
    .errValid     (errValid),
    .errAddr      (errAddr),
    .errExpected  (errExpected),
    .errObserved  (errObserved)
  );

endmodule

// File: tb/test_replay_checker.sv
`timescale 1ns/1ps
module test_replay_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        rptValid = 1'b0;
  logic        rptReady;
  logic [9:0]  rptAddr = '0;
  logic        rptIsStore = 1'b0;
  logic [31:0] rptData = '0;
  logic [15:0] rptTime = '0;
  logic        errPulse, errValid;
  logic [9:0]  errAddr;
  logic [31:0] errExpected, errObserved;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  replay_checker i_replay_checker (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rptValid(rptValid), .rptReady(rptReady),
    .rptAddr(rptAddr), .rptIsStore(rptIsStore), .rptData(rptData), .rptTime(rptTime),
    .errPulse(errPulse), .errValid(errValid), .errAddr(errAddr),
    .errExpected(errExpected), .errObserved(errObserved)
  );

  always @(negedge clk) if (errPulse) pulseCnt++;

  typedef struct packed {
    logic [3:0]  sc;
    logic [9:0]  addr;
    logic        st;
    logic [31:0] data;
    logic [15:0] t;
  } rptVec_t;

  typedef struct packed {
    logic [3:0]  pulses;
    logic        errV;
    logic [9:0]  addr;
    logic [31:0] expv;
    logic [31:0] obsv;
  } expVec_t;

  localparam int NRPT = 16;
  localparam int NSC  = 7;

  // Rows in arrival order.
  localparam rptVec_t RPT [NRPT] = '{
    '{4'd0, 10'd5,    1'b0, 32'h11, 16'd30},   // R3: load arrives before its store
    '{4'd0, 10'd5,    1'b1, 32'h11, 16'd20},
    '{4'd1, 10'd7,    1'b1, 32'hBB, 16'd40},   // R3: stale load detected
    '{4'd1, 10'd7,    1'b0, 32'hAA, 16'd50},
    '{4'd1, 10'd7,    1'b1, 32'hAA, 16'd10},
    '{4'd2, 10'd9,    1'b1, 32'h1,  16'd5},    // R4: equal stamps
    '{4'd2, 10'd9,    1'b1, 32'h2,  16'd5},
    '{4'd2, 10'd9,    1'b0, 32'h2,  16'd6},
    '{4'd3, 10'd12,   1'b0, 32'h0,  16'd1},    // R6: untouched word is zero
    '{4'd3, 10'd13,   1'b0, 32'h5,  16'd2},
    '{4'd4, 10'd3,    1'b1, 32'h1,  16'd1},    // R8: two mismatches
    '{4'd4, 10'd3,    1'b0, 32'h2,  16'd2},
    '{4'd4, 10'd20,   1'b0, 32'h9,  16'd3},
    '{4'd5, 10'h045,  1'b1, 32'd77, 16'd1},    // R5: aliasing on low 6 bits
    '{4'd5, 10'h005,  1'b0, 32'd77, 16'd2},
    '{4'd6, 10'd5,    1'b0, 32'h0,  16'd1}     // R9: shadow cleared by flush
  };

  localparam expVec_t EXPV [NSC] = '{
    '{4'd0, 1'b0, 10'd0,  32'h0,  32'h0},
    '{4'd1, 1'b1, 10'd7,  32'hBB, 32'hAA},
    '{4'd0, 1'b0, 10'd0,  32'h0,  32'h0},
    '{4'd1, 1'b1, 10'd13, 32'h0,  32'h5},
    '{4'd2, 1'b1, 10'd3,  32'h1,  32'h2},
    '{4'd0, 1'b0, 10'd0,  32'h0,  32'h0},
    '{4'd0, 1'b0, 10'd0,  32'h0,  32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Called on a negedge; returns on the negedge after the accepting edge.
  task automatic push(input logic [9:0] a, input logic s, input logic [31:0] d, input logic [15:0] t);
    rptValid = 1'b1; rptAddr = a; rptIsStore = s; rptData = d; rptTime = t;
    while (!rptReady) @(negedge clk);
    @(negedge clk);
    rptValid = 1'b0;
  endtask

  task automatic doFlush();
    flush = 1'b1;
    @(negedge clk);
    check("R9 ready low during flush", 32'(rptReady), 32'd0);
    flush = 1'b0;
    @(negedge clk);
  endtask

  // Fill with late-stamped stores to word 63 so all real reports get released.
  task automatic drain();
    for (int k = 0; k < 16; k++) push(10'd63, 1'b1, 32'h0, 16'hFFFF);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 ready after reset", 32'(rptReady), 32'd1);
    check("R10 errPulse after reset", 32'(errPulse), 32'd0);
    check("R10 errValid after reset", 32'(errValid), 32'd0);

    // Table-driven scenarios
    for (int sc = 0; sc < NSC; sc++) begin
      doFlush();
      check("R9 error cleared by flush", 32'(errValid), 32'd0);
      base = pulseCnt;
      for (int r = 0; r < NRPT; r++)
        if (RPT[r].sc == 4'(sc)) push(RPT[r].addr, RPT[r].st, RPT[r].data, RPT[r].t);
      drain();
      check($sformatf("R3/R7 pulse count sc%0d", sc), 32'(pulseCnt - base), 32'(EXPV[sc].pulses));
      check($sformatf("R8 errValid sc%0d", sc), 32'(errValid), 32'(EXPV[sc].errV));
      if (EXPV[sc].errV) begin
        check($sformatf("R8 errAddr sc%0d", sc), 32'(errAddr), 32'(EXPV[sc].addr));
        check($sformatf("R8 errExpected sc%0d", sc), errExpected, EXPV[sc].expv);
        check($sformatf("R8 errObserved sc%0d", sc), errObserved, EXPV[sc].obsv);
      end
    end

    // R2 / R7: window release and pulse timing
    doFlush();
    base = pulseCnt;
    push(10'd1, 1'b0, 32'h5, 16'd1);
    for (int k = 0; k < 14; k++) push(10'd2, 1'b1, 32'(k), 16'(10 + k));
    repeat (5) @(negedge clk);
    check("R2 nothing released below full", 32'(pulseCnt - base), 32'd0);
    check("R2 ready with 15 buffered", 32'(rptReady), 32'd1);
    push(10'd2, 1'b1, 32'h99, 16'd99);
    check("R2 ready low when full", 32'(rptReady), 32'd0);
    check("R7 no pulse one edge early", 32'(errPulse), 32'd0);
    @(negedge clk);
    check("R2 ready back after release", 32'(rptReady), 32'd1);
    check("R7 no pulse at release edge", 32'(errPulse), 32'd0);
    @(negedge clk);
    check("R7 pulse two edges after fill", 32'(errPulse), 32'd1);
    check("R7 errAddr", 32'(errAddr), 32'd1);
    check("R7 errExpected", errExpected, 32'd0);
    check("R7 errObserved", errObserved, 32'd5);
    @(negedge clk);
    check("R7 pulse lasts one cycle", 32'(errPulse), 32'd0);
    check("R8 errValid held", 32'(errValid), 32'd1);

    // R9: flush drops a pending bad load
    doFlush();
    check("R9 flush clears latch", 32'(errValid), 32'd0);
    push(10'd4, 1'b0, 32'h3, 16'd1);
    doFlush();
    base = pulseCnt;
    drain();
    check("R9 flushed load never checked", 32'(pulseCnt - base), 32'd0);
    check("R9 no error after flush", 32'(errValid), 32'd0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule